// File: doc/BRIEF.md
# Two-State-Bit Mealy Sequence Machine

This block is a small clocked sequential machine with one serial input bit and one output bit. Two D-type state bits, called A and B here, are updated on each rising clock edge by fixed next-state equations. A takes (A OR B) AND x. B takes (NOT A) AND x. The output is a Mealy output, y = (A OR B) AND (NOT x). It is computed combinationally from the present state and the live input, so y can move in the middle of a clock period when x moves.

When x is low on a clock edge, the machine falls back to state 00 from any state. A run of ones walks the state through a fixed order: 00, then 01, then 11, then 10, and it stays at 10 while x remains high. An active-high reset forces the state to 00. The parameter `ASYNC_RESET` chooses a synchronous reset (0, the default) or an asynchronous one (1). Both state bits are brought out on ports for observation. Inputs are expected to be synchronous to the clock already.

Top module: `mealy_two_flop`

## Requirements
- R1: While `rst` is high, the next rising clock edge leaves `stateA` = 0 and `stateB` = 0. With `ASYNC_RESET` = 1 the state also clears without waiting for a clock edge.
- R2: On each rising edge with `rst` low, `stateA` takes the value (`stateA` OR `stateB`) AND `xIn`, where the operands are the values just before the edge.
- R3: On each rising edge with `rst` low, `stateB` takes the value (NOT `stateA`) AND `xIn`, where the operands are the values just before the edge.
- R4: `yOut` equals (`stateA` OR `stateB`) AND (NOT `xIn`) at all times. It is 0 in state 00 for either input value, and 0 whenever `xIn` is 1.
- R5: A rising edge taken with `xIn` = 0 leaves the state at 00, whatever the state was before the edge.
- R6: From state 00, written as A then B, an edge with `xIn` = 1 gives state 01. From state 01, such an edge gives state 11.
- R7: From state 10 or 11, an edge with `xIn` = 1 gives state 10. A long run of ones therefore settles at 10.
- R8: In a non-zero state, a change of `xIn` between clock edges changes `yOut` within the same clock period, with no clock edge in between.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Active-high reset to state 00 |
| xIn | input | 1 | Serial input bit |
| yOut | output | 1 | Mealy output |
| stateA | output | 1 | State bit A |
| stateB | output | 1 | State bit B |

## Verification
A wrong state bit is visible on `stateA` or `stateB` one edge after the faulty transition. It also shows on `yOut` in that same period whenever `xIn` is low, because the output then reflects A OR B. A fault in the output logic alone leaves the state correct, so it can only be seen by sampling `yOut` in the middle of a period for both input values in every state. A bad transition spreads at most one further edge before the next zero input clears it back to 00. For that reason, each of the eight state and input pairs is reached on purpose and checked individually.

// File: rtl/mealy_pkg.sv
package mealy_pkg;
  typedef struct packed {
    logic a;
    logic b;
  } stateBits_t;

  typedef struct packed {
    logic loadA;
    logic loadB;
  } nextStrobe_t;
endpackage

// File: rtl/mealy_ctrl.sv
module mealy_ctrl
  import mealy_pkg::*;
(
  input  stateBits_t  curState,
  input  logic        xIn,
  output nextStrobe_t strobe,
  output logic        yOut
);
  logic anySet;

  always_comb begin
    anySet       = curState.a | curState.b;
    strobe.loadA = anySet & xIn;
    strobe.loadB = ~curState.a & xIn;
    yOut         = anySet & ~xIn;
  end
endmodule

// File: rtl/mealy_dpath.sv
module mealy_dpath
  import mealy_pkg::*;
#(
  parameter bit ASYNC_RESET = 1'b0
) (
  input  logic        clk,
  input  logic        rst,
  input  nextStrobe_t strobe,
  output stateBits_t  curState
);
  stateBits_t stateQ;

  generate
    if (ASYNC_RESET) begin : gAsync
      always_ff @(posedge clk or posedge rst) begin
        if (rst) stateQ <= '0;
        else begin
          stateQ.a <= strobe.loadA;
          stateQ.b <= strobe.loadB;
        end
      end
    end else begin : gSync
      always_ff @(posedge clk) begin
        if (rst) stateQ <= '0;
        else begin
          stateQ.a <= strobe.loadA;
          stateQ.b <= strobe.loadB;
        end
      end
    end
  endgenerate

  assign curState = stateQ;
endmodule

// File: rtl/mealy_two_flop.sv
module mealy_two_flop
  import mealy_pkg::*;
#(
  parameter bit ASYNC_RESET = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic xIn,
  output logic yOut,
  output logic stateA,
  output logic stateB
);
  stateBits_t  curState;
  nextStrobe_t strobe;

  mealy_ctrl ctrl_i (
    .curState (curState),
    .xIn      (xIn),
    .strobe   (strobe),
    .yOut     (yOut)
  );

  mealy_dpath #(.ASYNC_RESET(ASYNC_RESET)) dpath_i (
    .clk      (clk),
    .rst      (rst),
    .strobe   (strobe),
    .curState (curState)
  );

  assign stateA = curState.a;
  assign stateB = curState.b;
endmodule

// File: rtl/mealy_two_flop_chk.sv
module mealy_two_flop_chk (
  input logic clk,
  input logic rst,
  input logic xIn,
  input logic yOut,
  input logic stateA,
  input logic stateB
);
  assert_reset_clear_R1: assert property (@(posedge clk)
    rst |=> (!stateA && !stateB));

  assert_next_a_R2: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (stateA == (($past(stateA) | $past(stateB)) & $past(xIn))));

  assert_next_b_R3: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (stateB == (!$past(stateA) && $past(xIn))));

  assert_out_high_R4: assert property (@(posedge clk) disable iff (rst)
    (!xIn && (stateA || stateB)) |-> yOut);

  assert_out_low_R4: assert property (@(posedge clk) disable iff (rst)
    (xIn || (!stateA && !stateB)) |-> !yOut);

  assert_zero_return_R5: assert property (@(posedge clk) disable iff (rst)
    !xIn |=> (!stateA && !stateB));

  assert_walk_R6: assert property (@(posedge clk) disable iff (rst)
    (!stateA && !stateB && xIn) |=> (!stateA && stateB));

  assert_hold_R7: assert property (@(posedge clk) disable iff (rst)
    (stateA && xIn) |=> (stateA && !stateB));
endmodule

bind mealy_two_flop mealy_two_flop_chk chk_i (
  .clk    (clk),
  .rst    (rst),
  .xIn    (xIn),
  .yOut   (yOut),
  .stateA (stateA),
  .stateB (stateB)
);

// File: tb/mealy_two_flop_tb_top.sv
`timescale 1ns/1ps
module mealy_two_flop_tb_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic xIn = 1'b0;
  logic yOut, stateA, stateB;
  int checks = 0;
  int errors = 0;
  logic expA = 1'b0;
  logic expB = 1'b0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  mealy_two_flop dut_i (
    .clk(clk), .rst(rst), .xIn(xIn),
    .yOut(yOut), .stateA(stateA), .stateB(stateB)
  );

  function automatic logic modelY(logic a, logic b, logic x);
    return (a | b) & ~x;
  endfunction
  function automatic logic modelA(logic a, logic b, logic x);
    return (a | b) & x;
  endfunction
  function automatic logic modelB(logic a, logic b, logic x);
    return ~a & x;
  endfunction

  task automatic check1(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic checkState(input string req);
    check1({req, " A"}, stateA, expA);
    check1({req, " B"}, stateB, expB);
  endtask

  // Drive x after a falling edge, check y mid-period, clock, then check state.
  task automatic step(input logic xv, input string req);
    logic na, nb;
    @(negedge clk);
    xIn = xv;
    #1;
    check1({"R4 ", req}, yOut, modelY(expA, expB, xv));
    na = modelA(expA, expB, xv);
    nb = modelB(expA, expB, xv);
    @(posedge clk);
    #1;
    expA = na;
    expB = nb;
    checkState({"R2/R3 ", req});
  endtask

  task automatic goZero();
    step(1'b0, "R5 clear");
  endtask

  initial begin
    #100000;
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(posedge clk);
    #1;
    check1("R1 reset A", stateA, 1'b0);
    check1("R1 reset B", stateB, 1'b0);
    check1("R1 reset y", yOut, 1'b0);
    @(negedge clk);
    rst = 1'b0;

    // R6 / R7 walk: 00 -> 01 -> 11 -> 10 -> 10
    step(1'b1, "R6 00->01");
    check1("R6 at01", {stateA, stateB} == 2'b01, 1'b1);
    step(1'b1, "R6 01->11");
    check1("R6 at11", {stateA, stateB} == 2'b11, 1'b1);
    step(1'b1, "R7 11->10");
    check1("R7 at10", {stateA, stateB} == 2'b10, 1'b1);
    step(1'b1, "R7 10->10");
    check1("R7 hold10", {stateA, stateB} == 2'b10, 1'b1);

    // All eight state/input pairs: reach state with k ones, then apply x.
    for (int k = 0; k < 4; k++) begin
      for (int xv = 0; xv < 2; xv++) begin
        goZero();
        for (int j = 0; j < k; j++) step(1'b1, "R6 reach");
        step(logic'(xv), (xv == 0) ? "R5 pair" : "R7 pair");
      end
    end

    // R8: y follows x inside one period in state 11.
    goZero();
    step(1'b1, "R8 prep");
    step(1'b1, "R8 prep");
    @(negedge clk);
    xIn = 1'b0;
    #0.5;
    check1("R8 y rises", yOut, 1'b1);
    xIn = 1'b1;
    #0.5;
    check1("R8 y falls", yOut, 1'b0);
    xIn = 1'b0;
    #0.5;
    check1("R8 y rises again", yOut, 1'b1);
    @(posedge clk);
    #1;
    expA = 1'b0;
    expB = 1'b0;
    checkState("R5 after R8");

    // Random stream.
    for (int i = 0; i < 400; i++) begin
      step(logic'($urandom_range(1, 0)), "random");
    end

    // Reset in a non-zero state.
    step(1'b1, "R1 prep");
    @(negedge clk);
    rst = 1'b1;
    xIn = 1'b1;
    @(posedge clk);
    #1;
    check1("R1 mid-run A", stateA, 1'b0);
    check1("R1 mid-run B", stateB, 1'b0);
    @(negedge clk);
    rst = 1'b0;

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule